// File: doc/BRIEF.md
# Round-Robin P-Bit Ising Sampler

This block keeps a small array of probabilistic bits (p-bits) together with a signed coupling weight for every ordered pair of them. It revisits the bits one at a time in a fixed rotating order. For the bit under update it adds up its neighbours' couplings, each signed by the neighbour's current spin. It offsets that net field by the midpoint 128 and clamps the result into an 8-bit threshold. The bit's new state is the comparison of a random byte from outside against that threshold.

A host loads the coupling weights through a simple address/data write port. An external entropy source supplies random bytes with a valid strobe, and a run enable gates the sampling. With all weights at zero every bit is a fair coin. Positive couplings pull a pair of bits toward agreement and negative couplings push them apart, so the array drifts toward low-energy configurations of the Ising problem written into the weights.

Top module: `pbit_sampler`

## Requirements
- R1: A synchronous active-high reset clears all six spins to 0, points the update pointer at bit 0 and sets every coupling weight to 0.
- R2: An update happens only on a clock edge where `run` and `rnd_valid` are both high. On any other edge the spins and the pointer hold, and a coupling write on such an edge leaves the spins unchanged.
- R3: Successive updates visit bits 0,1,2,3,4,5 and then wrap to 0. Each update changes only the bit selected by the pointer.
- R4: Each weight is an 8-bit two's-complement value. For bit i the net field is the sum over j≠i of J[i][j] when spin j is 1 and −J[i][j] when spin j is 0, computed without overflow.
- R5: The threshold is 128 + net, clamped to 0..255. The updated bit becomes 1 exactly when `rnd_byte` is strictly less than the threshold. This means byte 255 always gives 0 at a saturated threshold of 255, and any byte gives 0 at a threshold of 0.
- R6: Diagonal weights J[i][i] (address i·7) are stored but never contribute to the net field.
- R7: A write with `cfg_we` high stores `cfg_data` into J[i][j] at `cfg_addr` = i·6 + j. Writes to addresses 36..63 change nothing.
- R8: With all couplings zero the threshold is 128, so byte 127 gives 1 and byte 128 gives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Coupling write enable |
| cfg_addr | input | 6 | Coupling address, row·6 + column |
| cfg_data | input | 8 | Signed coupling weight |
| run | input | 1 | Sampling enable |
| rnd_valid | input | 1 | Random byte valid strobe |
| rnd_byte | input | 8 | Random byte from the entropy source |
| spins | output | 6 | Current p-bit states |

## Verification
On every cycle the assertions check the following: the pointer stays in range and steps with wrap only on a qualified update, idle edges leave spins and pointer still, at most one spin changes per edge, and the weight store keeps what was written. They also check that a net field at or beyond either clamp rail forces the bit's outcome. The exact arithmetic of the net field, the exclusion of the diagonal, the ignored upper addresses and the strict comparison at the threshold boundary can only be shown by the bench's scenarios. These scenarios compare the spins against an independent model under chosen weights and bytes.

// File: rtl/pbit_pkg.sv
package pbit_pkg;

    localparam int PB_COUNT    = 6;
    localparam int PB_WEIGHT_W = 8;
    localparam int PB_MID      = 128;
    localparam int PB_TOP      = 255;

    // outcome of one bit decision
    typedef struct packed {
        logic [7:0] level;
        logic       fire;
    } verdict_t;

    function automatic logic [7:0] clamp_level(input int net);
        int t;
        t = PB_MID + net;
        if (t < 0)      return 8'd0;
        if (t > PB_TOP) return 8'd255;
        return t[7:0];
    endfunction

endpackage

// File: rtl/pbit_coupling_regs.sv
module pbit_coupling_regs #(
    parameter int N      = 6,
    parameter int W      = 8,
    parameter int ADDR_W = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic signed [W-1:0] wr_data,
    output logic signed [W-1:0] weights [N*N]
);
    localparam int CELLS = N * N;
    localparam logic [ADDR_W:0] CELLS_X = (ADDR_W+1)'(CELLS);

    logic in_range;
    assign in_range = ({1'b0, wr_addr} < CELLS_X);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < CELLS; k++) weights[k] <= '0;
        end else if (wr_en && in_range) begin
            weights[wr_addr] <= wr_data;
        end
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        (wr_en && in_range) |=> (weights[$past(wr_addr)] == $past(wr_data)))
        else $error("write did not land"); // R7

endmodule

// File: rtl/pbit_net_field.sv
module pbit_net_field #(
    parameter int N     = 6,
    parameter int W     = 8,
    parameter int IDX_W = 3,
    parameter int ACC_W = 12
) (
    input  logic signed [W-1:0]     row [N],
    input  logic [N-1:0]            spins,
    input  logic [IDX_W-1:0]        self_idx,
    output logic signed [ACC_W-1:0] net
);
    logic signed [ACC_W-1:0] term [N];

    for (genvar j = 0; j < N; j++) begin : g_term
        logic signed [ACC_W-1:0] wide;
        assign wide    = ACC_W'(row[j]);
        assign term[j] = (self_idx == IDX_W'(j)) ? '0
                       : (spins[j] ? wide : -wide);
    end

    always_comb begin
        net = '0;
        for (int j = 0; j < N; j++) net = net + term[j];
    end

endmodule

// File: rtl/pbit_decide.sv
module pbit_decide
    import pbit_pkg::*;
#(
    parameter int ACC_W = 12
) (
    input  logic signed [ACC_W-1:0] net,
    input  logic [7:0]              rnd,
    output verdict_t                verdict
);
    always_comb begin
        verdict.level = clamp_level(int'(net));
        verdict.fire  = (rnd < verdict.level);
    end
endmodule

// File: rtl/pbit_sampler.sv
module pbit_sampler
    import pbit_pkg::*;
#(
    parameter  int N      = PB_COUNT,
    parameter  int W      = PB_WEIGHT_W,
    localparam int IDX_W  = $clog2(N),
    localparam int ADDR_W = $clog2(N*N),
    localparam int ACC_W  = W + $clog2(N) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [W-1:0]      cfg_data,
    input  logic              run,
    input  logic              rnd_valid,
    input  logic [7:0]        rnd_byte,
    output logic [N-1:0]      spins
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(N-1);

    logic signed [W-1:0]     weights [N*N];
    logic signed [W-1:0]     row [N];
    logic signed [ACC_W-1:0] net;
    logic [IDX_W-1:0]        ptr;
    verdict_t                verdict;
    logic                    step;

    assign step = run && rnd_valid;

    pbit_coupling_regs #(.N(N), .W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_addr (cfg_addr),
        .wr_data (cfg_data),
        .weights (weights)
    );

    always_comb begin
        for (int j = 0; j < N; j++) row[j] = weights[int'(ptr) * N + j];
    end

    pbit_net_field #(.N(N), .W(W), .IDX_W(IDX_W), .ACC_W(ACC_W)) u_net (
        .row      (row),
        .spins    (spins),
        .self_idx (ptr),
        .net      (net)
    );

    pbit_decide #(.ACC_W(ACC_W)) u_decide (
        .net     (net),
        .rnd     (rnd_byte),
        .verdict (verdict)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            spins <= '0;
            ptr   <= '0;
        end else if (step) begin
            spins[ptr] <= verdict.fire;
            ptr        <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (spins == '0 && ptr == '0))
        else $error("reset state wrong"); // R1
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> ($stable(spins) && $stable(ptr)))
        else $error("idle edge moved state"); // R2
    AST_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < N)
        else $error("pointer out of range"); // R3
    AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> (ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)))
        else $error("pointer order broken"); // R3
    AST_SINGLE_FLIP: assert property (@(posedge clk) disable iff (rst)
        step |=> ($countones(spins ^ $past(spins)) <= 1))
        else $error("more than one spin changed"); // R3
    AST_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (step && net <= -ACC_W'(PB_MID)) |=> !spins[$past(ptr)])
        else $error("floor clamp violated"); // R5
    AST_CEIL: assert property (@(posedge clk) disable iff (rst)
        (step && net >= ACC_W'(PB_TOP - PB_MID) && rnd_byte != 8'hFF)
        |=> spins[$past(ptr)])
        else $error("ceiling clamp violated"); // R5

endmodule

// File: tb/pbit_sampler_test.sv
`timescale 1ns/1ps
module pbit_sampler_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [5:0] cfg_addr = '0;
    logic [7:0] cfg_data = '0;
    logic       run = 1'b0;
    logic       rnd_valid = 1'b0;
    logic [7:0] rnd_byte = '0;
    logic [5:0] spins;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    int       mj [36];
    bit [5:0] ms;
    int       mp;
    bit [15:0] lf = 16'hACE1;

    always #2.5 clk = ~clk;

    pbit_sampler uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_data(cfg_data), .run(run), .rnd_valid(rnd_valid),
        .rnd_byte(rnd_byte), .spins(spins)
    );

    function automatic bit [7:0] next_rand();
        for (int k = 0; k < 8; k++)
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        return lf[7:0];
    endfunction

    function automatic int model_level();
        int net = 0;
        int t;
        for (int j = 0; j < 6; j++)
            if (j != mp) net += ms[j] ? mj[mp*6+j] : -mj[mp*6+j];
        t = 128 + net;
        if (t < 0) t = 0;
        if (t > 255) t = 255;
        return t;
    endfunction

    task automatic check(input string req, input bit [5:0] act, input bit [5:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: spins actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        cfg_we = 1'b1; cfg_addr = a[5:0]; cfg_data = d[7:0];
        @(negedge clk);
        cfg_we = 1'b0;
        if (a < 36) mj[a] = d;
    endtask

    task automatic fill(input int offdiag, input int diag);
        for (int a = 0; a < 36; a++) wr(a, (a % 7 == 0) ? diag : offdiag);
    endtask

    task automatic upd(input bit [7:0] b, input string req);
        bit [5:0] e = ms;
        e[mp] = (int'(b) < model_level());
        run = 1'b1; rnd_valid = 1'b1; rnd_byte = b;
        @(negedge clk);
        run = 1'b0; rnd_valid = 1'b0;
        ms = e;
        mp = (mp + 1) % 6;
        check(req, spins, ms);
    endtask

    task automatic t_reset();
        check("R1 reset clears spins", spins, 6'b0);
        upd(8'd127, "R8 zero weights byte 127 gives 1 at bit 0 (R1 pointer 0)");
        upd(8'd128, "R8 zero weights byte 128 gives 0");
    endtask

    task automatic t_hold();
        run = 1'b0; rnd_valid = 1'b1; rnd_byte = 8'd0;
        @(negedge clk);
        check("R2 valid without run holds", spins, ms);
        run = 1'b1; rnd_valid = 1'b0;
        @(negedge clk);
        run = 1'b0;
        check("R2 run without valid holds", spins, ms);
        wr(3, 100);
        check("R2 write on idle edge holds spins", spins, ms);
        upd(8'd0, "R2 pointer held across idle edges");
    endtask

    task automatic t_order();
        fill(0, 0);
        for (int k = 0; k < 7; k++) upd(8'd0, "R3 round robin sets next bit");
        for (int k = 0; k < 7; k++) upd(8'd255, "R3 round robin clears next bit with wrap");
    endtask

    task automatic t_clamp();
        fill(0, 0);
        for (int k = 0; k < 6; k++) upd(8'd0, "R3 prepare all ones");
        fill(127, 0);
        upd(8'd254, "R5 saturated high threshold byte 254 gives 1");
        upd(8'd255, "R5 saturated high threshold byte 255 gives 0");
        fill(0, 0);
        for (int k = 0; k < 6; k++) upd(8'd0, "R3 prepare all ones");
        fill(-128, 0);
        upd(8'd0, "R5 saturated low threshold byte 0 gives 0");
        upd(8'd0, "R5 low clamp second bit");
    endtask

    task automatic t_diag();
        fill(0, 127);
        for (int k = 0; k < 6; k++) upd(8'd128, "R6 diagonal ignored byte 128 gives 0");
        fill(0, -128);
        for (int k = 0; k < 6; k++) upd(8'd127, "R6 diagonal ignored byte 127 gives 1");
    endtask

    task automatic t_addr();
        fill(0, 0);
        for (int a = 36; a < 64; a++) wr(a, 127);
        for (int k = 0; k < 6; k++) upd(8'd128, "R7 upper addresses change nothing");
        wr(2*6+4, 60);
        wr(4*6+1, -90);
        for (int k = 0; k < 12; k++) upd(8'd100, "R4 R7 single weight at i*6+j");
        for (int k = 0; k < 6; k++) upd(8'd170, "R4 single weight other sign");
    endtask

    task automatic t_random();
        for (int a = 0; a < 36; a++) wr(a, int'($signed(next_rand())));
        for (int k = 0; k < 300; k++) begin
            bit [7:0] r = next_rand();
            if (r[1:0] == 2'b00) begin
                run = r[2]; rnd_valid = ~r[2]; rnd_byte = next_rand();
                @(negedge clk);
                run = 1'b0; rnd_valid = 1'b0;
                check("R2 random idle holds", spins, ms);
            end else begin
                upd(next_rand(), "R4 R5 random weights and bytes");
            end
        end
        for (int a = 0; a < 36; a++) wr(a, (k_sign(a)) ? 100 : -100);
        for (int k = 0; k < 60; k++) upd(next_rand(), "R4 R5 large mixed weights");
    endtask

    function automatic bit k_sign(input int a);
        return ((a / 6) + (a % 6)) % 2 == 0;
    endfunction

    initial begin
        for (int a = 0; a < 36; a++) mj[a] = 0;
        ms = '0; mp = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_hold();
        t_order();
        t_clamp();
        t_diag();
        t_addr();
        t_random();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            errors++; checks++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule